// File: doc/BRIEF.md
# Neural-Network Binary Channel Equalizer

This block cleans up a noisy, sampled, unipolar NRZ data stream. It uses a small feed-forward network with a tapped delay line in front of it. Each accepted input sample is a signed fixed-point value. The block combines that sample with the nine accepted samples before it into a ten-sample observation window.

A single linear hidden neuron forms a weighted sum of the window plus an offset. A single output neuron scales that sum, adds its own offset, and clamps the result into the range zero to one. The output is an unsigned fixed-point estimate of the transmitted bit. A slicer further down the chain turns that estimate into a decision.

The network is fully parallel and yields one estimate per accepted sample. All coefficients are fixed at build time from offline training. The internal arithmetic keeps full precision, and the result is cut down only at the very end.

Top module: `tdnn_equalizer`

## Requirements
- R1: The observation window is the current sample plus the nine previously accepted samples. Tap 0 is the newest sample and tap 9 the oldest. A sample presented while `sample_valid_i` is low does not enter the window.
- R2: `sample_i` is 11-bit two's complement with 7 fractional bits (value = code / 128), and the whole range -1024..1023 is processed correctly.
- R3: The hidden value is the exact sum over taps of `tap[i] * HID_W[i]` plus `HID_B`, with identity activation. Coefficients are signed with 12 fractional bits. No rounding and no overflow occur.
- R4: The pre-clamp output is the exact value `hidden * OUT_WT + OUT_B`, with both coefficients holding 12 fractional bits.
- R5: The exact output value is reduced to 7 fractional bits by rounding toward negative infinity (floor). This happens before the clamp.
- R6: The reduced value is clamped as follows. Below 0 it gives 0. Above 128 (1.0) it gives 128. Otherwise it passes through. `est_o` is unsigned with 1 integer and 7 fractional bits, so 0x80 means exactly 1.0, and the top bit set implies that all lower bits are clear.
- R7: `est_valid_o` is high exactly two clocks after the `sample_valid_i` that produced it. `est_o` holds its value while `est_valid_o` is low.
- R8: An active-low asynchronous reset clears the delay line and both pipeline stages. `est_o` and `est_valid_o` read 0 during and after reset, and the first window after reset treats the missing older samples as zero.
- R9: Samples accepted on consecutive clocks each produce an estimate on consecutive clocks, with no bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Accept `sample_i` and advance the delay line |
| sample_i | input | 11 | Signed input sample, 7 fractional bits |
| est_valid_o | output | 1 | `est_o` updated this cycle |
| est_o | output | 8 | Unsigned bit estimate, 1.7 format |

## Verification
The two functions that can coincide are the floor reduction and the clamp. A value just below zero floors to a negative code and must then clamp to 0. A value at or just above 1.0 must come out as exactly 0x80.

These cases are provoked in three ways:
- streams of samples pinned at full scale, positive and negative;
- full-range random samples;
- noisy NRZ symbols whose pre-clamp value lands near both limits.

Every estimate is judged bit-exactly against an integer model in the bench that applies floor and clamp in that order.

// File: rtl/tdnn_pkg.sv
package tdnn_pkg;
  localparam int unsigned TAPS_DEF  = 10;
  localparam int unsigned IN_W_DEF  = 11;
  localparam int unsigned IN_F_DEF  = 7;
  localparam int unsigned CW_DEF    = 16;
  localparam int unsigned CF_DEF    = 12;
  localparam int unsigned OUT_F_DEF = 7;

  // Sum of taps products plus bias, with one guard bit.
  function automatic int unsigned acc_width(int unsigned in_w, int unsigned cw, int unsigned taps);
    return in_w + cw + $clog2(taps) + 1;
  endfunction
endpackage

// File: rtl/tdnn_delay_line.sv
module tdnn_delay_line #(
  parameter int unsigned TAPS = 10,
  parameter int unsigned IN_W = 11
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       adv_i,
  input  logic [IN_W-1:0]            sample_i,
  output logic [TAPS-1:0][IN_W-1:0]  win_o
);
  logic [TAPS-2:0][IN_W-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
    end else if (adv_i) begin
      dly_q[0] <= sample_i;
      for (int i = 1; i < int'(TAPS) - 1; i++) dly_q[i] <= dly_q[i-1];
    end
  end

  assign win_o[0] = sample_i;
  for (genvar g = 1; g < TAPS; g++) begin : g_tap
    assign win_o[g] = dly_q[g-1];
  end
endmodule

// File: rtl/tdnn_hidden_neuron.sv
module tdnn_hidden_neuron #(
  parameter int unsigned TAPS  = 10,
  parameter int unsigned IN_W  = 11,
  parameter int unsigned IN_F  = 7,
  parameter int unsigned CW    = 16,
  parameter int unsigned ACC_W = 32,
  parameter logic [TAPS-1:0][CW-1:0] W = '0,
  parameter int B = 0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       vld_i,
  input  logic [TAPS-1:0][IN_W-1:0]  win_i,
  output logic                       vld_o,
  output logic signed [ACC_W-1:0]    hid_o
);
  localparam int unsigned PW = IN_W + CW;
  // Bias has CF fractional bits; products have IN_F+CF.
  localparam logic signed [ACC_W-1:0] B_AL = ACC_W'(longint'(B) * (longint'(1) << IN_F));

  logic signed [PW-1:0]    prod [TAPS];
  logic signed [ACC_W-1:0] acc;

  for (genvar g = 0; g < TAPS; g++) begin : g_mul
    assign prod[g] = PW'($signed(win_i[g])) * PW'($signed(W[g]));
  end

  always_comb begin
    acc = B_AL;
    for (int i = 0; i < int'(TAPS); i++) acc = acc + ACC_W'(prod[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      hid_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) hid_o <= acc;
    end
  end
endmodule

// File: rtl/tdnn_output_neuron.sv
module tdnn_output_neuron #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned CW    = 16,
  parameter int unsigned IN_F  = 7,
  parameter int unsigned CF    = 12,
  parameter int unsigned OUT_F = 7,
  parameter int W = 0,
  parameter int B = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic signed [ACC_W-1:0]  hid_i,
  output logic                     vld_o,
  output logic [OUT_F:0]           est_o
);
  localparam int unsigned PW    = ACC_W + CW + 1;
  localparam int unsigned FRAC  = IN_F + 2 * CF;
  localparam int unsigned SHIFT = FRAC - OUT_F;
  localparam logic signed [PW-1:0] B_AL = PW'(longint'(B) * (longint'(1) << (IN_F + CF)));
  localparam logic signed [PW-1:0] W_S  = PW'(longint'(W));
  localparam logic signed [PW-1:0] ONE  = PW'(longint'(1) << OUT_F);

  logic signed [PW-1:0] full;
  logic signed [PW-1:0] flr;
  logic [OUT_F:0]       est_d;

  assign full = PW'(hid_i) * W_S + B_AL;
  assign flr  = full >>> SHIFT;  // floor before clamp

  always_comb begin
    if (flr < 0)        est_d = '0;
    else if (flr > ONE) est_d = ONE[OUT_F:0];
    else                est_d = flr[OUT_F:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      est_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) est_o <= est_d;
    end
  end
endmodule

// File: rtl/tdnn_equalizer.sv
module tdnn_equalizer #(
  parameter int unsigned TAPS  = tdnn_pkg::TAPS_DEF,
  parameter int unsigned IN_W  = tdnn_pkg::IN_W_DEF,
  parameter int unsigned IN_F  = tdnn_pkg::IN_F_DEF,
  parameter int unsigned CW    = tdnn_pkg::CW_DEF,
  parameter int unsigned CF    = tdnn_pkg::CF_DEF,
  parameter int unsigned OUT_F = tdnn_pkg::OUT_F_DEF,
  parameter logic [TAPS-1:0][CW-1:0] HID_W = {
    -16'sd120, 16'sd190, 16'sd230, 16'sd270, 16'sd310,
    16'sd350, 16'sd390, 16'sd430, 16'sd480, 16'sd520},
  parameter int HID_B  = -205,
  parameter int OUT_WT = 4506,
  parameter int OUT_B  = 82
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sample_valid_i,
  input  logic [IN_W-1:0] sample_i,
  output logic            est_valid_o,
  output logic [OUT_F:0]  est_o
);
  localparam int unsigned ACC_W = tdnn_pkg::acc_width(IN_W, CW, TAPS);

  logic [TAPS-1:0][IN_W-1:0] win;
  logic                      hid_vld;
  logic signed [ACC_W-1:0]   hid;

  tdnn_delay_line #(.TAPS(TAPS), .IN_W(IN_W)) u_dly (
    .clk_i, .rst_ni, .adv_i(sample_valid_i), .sample_i, .win_o(win)
  );

  tdnn_hidden_neuron #(
    .TAPS(TAPS), .IN_W(IN_W), .IN_F(IN_F), .CW(CW), .ACC_W(ACC_W), .W(HID_W), .B(HID_B)
  ) u_hid (
    .clk_i, .rst_ni, .vld_i(sample_valid_i), .win_i(win), .vld_o(hid_vld), .hid_o(hid)
  );

  tdnn_output_neuron #(
    .ACC_W(ACC_W), .CW(CW), .IN_F(IN_F), .CF(CF), .OUT_F(OUT_F), .W(OUT_WT), .B(OUT_B)
  ) u_out (
    .clk_i, .rst_ni, .vld_i(hid_vld), .hid_i(hid), .vld_o(est_valid_o), .est_o
  );
endmodule

// File: rtl/tdnn_equalizer_chk.sv
module tdnn_equalizer_chk #(
  parameter int unsigned OUT_F = 7
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           sample_valid_i,
  input logic           est_valid_o,
  input logic [OUT_F:0] est_o
);
  localparam logic [OUT_F:0] ONE = (OUT_F+1)'(1) << OUT_F;
  logic [1:0] live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          live_q <= '0;
    else if (live_q != 2) live_q <= live_q + 2'd1;
  end

  p_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q == 2'd2) |-> (est_valid_o == $past(sample_valid_i, 2)));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((live_q != 2'd0) && !est_valid_o) |-> $stable(est_o));

  p_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    est_o <= ONE);

  p_exact_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    est_o[OUT_F] |-> (est_o[OUT_F-1:0] == '0));

  p_reset_r8: assert property (@(posedge clk_i)
    !rst_ni |-> (est_o == '0 && !est_valid_o));
endmodule

bind tdnn_equalizer tdnn_equalizer_chk #(.OUT_F(OUT_F)) u_chk (.*);

// File: tb/tdnn_equalizer_test.sv
module tdnn_equalizer_test;
  localparam logic [9:0][15:0] W_H = {
    -16'sd120, 16'sd190, 16'sd230, 16'sd270, 16'sd310,
    16'sd350, 16'sd390, 16'sd430, 16'sd480, 16'sd520};
  localparam int HB = -205;
  localparam int OW = 4506;
  localparam int OB = 82;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_valid_i = 1'b0;
  logic [10:0] sample_i = '0;
  logic        est_valid_o;
  logic [7:0]  est_o;

  tdnn_equalizer #(.HID_W(W_H), .HID_B(HB), .OUT_WT(OW), .OUT_B(OB)) uut (
    .clk_i(clk), .rst_ni, .sample_valid_i, .sample_i, .est_valid_o, .est_o
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint     hist [9];
  logic       p1_v, p2_v;
  logic [7:0] p1_d, p2_d, last_est;

  task automatic fail(input string tag, input string what, input longint act, input longint exp);
    errors++;
    $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  task automatic model_clear();
    foreach (hist[i]) hist[i] = 0;
    p1_v = 0; p2_v = 0; p1_d = 0; p2_d = 0; last_est = 0;
  endtask

  // Integer reference: exact sum, floor to 7 fractional bits, then clamp.
  function automatic logic [7:0] model(input logic [10:0] s);
    longint h, o, q;
    h = longint'(HB) * 128 + longint'($signed(s)) * longint'($signed(W_H[0]));
    for (int i = 1; i < 10; i++) h += hist[i-1] * longint'($signed(W_H[i]));
    o = h * OW + longint'(OB) * (longint'(1) << 19);
    q = o >>> 24;
    for (int i = 8; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = longint'($signed(s));
    if (q < 0) return 8'd0;
    if (q > 128) return 8'd128;
    return q[7:0];
  endfunction

  task automatic step(input logic v, input logic [10:0] s, input string tag);
    @(negedge clk);
    checks++;
    if (est_valid_o !== p2_v) fail("R7", "est_valid_o", longint'(est_valid_o), longint'(p2_v));
    checks++;
    if (p2_v) begin
      if (est_o !== p2_d) fail(tag, "est_o", longint'(est_o), longint'(p2_d));
      last_est = p2_d;
    end else if (est_o !== last_est) begin
      fail("R7", "est_o hold", longint'(est_o), longint'(last_est));
    end
    p2_v = p1_v; p2_d = p1_d;
    p1_v = v;
    if (v) p1_d = model(s);
    sample_valid_i = v;
    sample_i = s;
  endtask

  task automatic flush(input string tag);
    repeat (3) step(1'b0, 11'($urandom_range(0, 2047)), tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; sample_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (est_o !== 8'd0 || est_valid_o !== 1'b0)
      fail("R8", "outputs in reset", longint'({est_valid_o, est_o}), 0);
    rst_ni = 1'b1;
    model_clear();
  endtask

  task automatic t_reset_window();
    do_reset();
    step(1'b1, 11'sd300, "R8");
    flush("R8");
  endtask

  task automatic t_full_range();
    for (int n = 0; n < 400; n++) step(1'b1, 11'($urandom_range(0, 2047)), "R2/R3/R4/R5");
    flush("R2");
  endtask

  task automatic t_noisy_nrz();
    for (int b = 0; b < 60; b++) begin
      int lvl = ($urandom_range(0, 1) == 1) ? 128 : 0;
      for (int k = 0; k < 10; k++)
        step(1'b1, 11'(lvl + int'($urandom_range(0, 320)) - 160), "R5/R6/R9");
    end
    flush("R9");
  endtask

  task automatic t_gaps();
    for (int n = 0; n < 400; n++)
      step($urandom_range(0, 1) == 1, 11'($urandom_range(0, 2047)), "R1");
    flush("R1");
  endtask

  task automatic t_saturate();
    for (int n = 0; n < 15; n++) step(1'b1, 11'sd1023, "R6 high");
    for (int n = 0; n < 15; n++) step(1'b1, -11'sd1024, "R6 low");
    for (int n = 0; n < 15; n++) step(1'b1, 11'sd0, "R6 zero");
    flush("R6");
  endtask

  task automatic t_single();
    step(1'b1, 11'sd77, "R7");
    repeat (5) step(1'b0, 11'sd500, "R7");
  endtask

  initial begin
    model_clear();
    t_reset_window();
    t_single();
    t_full_range();
    t_noisy_nrz();
    t_gaps();
    t_saturate();
    t_reset_window();
    t_single();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule